// File: doc/BRIEF.md
# SDRAM Mode-Driven Command Sequencer

This block turns accesses on a simple request port into commands on a single-data-rate SDRAM command bus. A mode input chosen by firmware decides what every accepted access becomes. It can be a precharge of all banks, one auto-refresh, a load of the device mode register, or a normal single-beat read or write. Firmware brings the device up by stepping this mode and issuing accesses: one precharge-all, a run of eight refreshes, one mode-register load, then normal operation. The controller has no power-up sequence of its own.

In normal mode each access opens the addressed row, issues the column command and closes the bank again (closed page). The count inputs are fixed by configuration and set the spacing between these commands. An interval timer runs only in normal mode and raises a pending refresh. That refresh waits for the access in progress to finish and then goes ahead of any new request. The request port holds ready low while a spacing count is still running or a refresh is pending. The data path, bursts longer than one beat and self-refresh are outside this block. Every count input must be at least 1.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset the bus carries NOP, ready is high and no refresh is pending.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as NOP 0111, ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO-REFRESH 0001, LOAD-MODE 0000. An accepted access puts its first command on the bus in the next clock.
- R3: With mode = 1 (precharge-all), one access issues exactly one PRECHARGE with address bit 10 high, and no command follows for at least cfg_trp clocks.
- R4: With mode = 2 (refresh), each access issues exactly one AUTO-REFRESH, and no command follows for at least cfg_trc clocks.
- R5: With mode = 3 (load-mode), an access issues LOAD-MODE. Its address bus carries the low bits of the word address, its bank bus carries the next bits, and no command follows for at least 3 clocks.
- R6: With mode = 0 (normal), an access issues ACTIVATE with row and bank, then READ or WRITE exactly cfg_trcd clocks later. The column command carries the column with address bit 10 low.
- R7: A normal access ends with a single-bank PRECHARGE (bit 10 low) on the same bank. It comes no earlier than cfg_tras clocks after ACTIVATE, and for a write no earlier than cfg_twr clocks after WRITE. Two ACTIVATEs are at least cfg_trc clocks apart.
- R8: The word address is the byte address shifted right by 1 when cfg_dbw16 = 1 and by 2 otherwise. The column is its low 8 + cfg_col_code bits (cfg_col_code 0..2), the row is the next 11 + cfg_row_code bits (cfg_row_code 0..2), and the bank is the next 1 + cfg_bank_code bits.
- R9: In normal mode a refresh falls due every cfg_ref_interval clocks. While the mode is anything else the timer is held and nothing is pending.
- R10: A due refresh never splits an access between ACTIVATE and PRECHARGE. Once that access is finished the refresh is issued before any new request, and ready stays low while it is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 normal, 1 precharge-all, 2 refresh, 3 load-mode |
| cfg_col_code | input | 2 | Column bits minus 8 |
| cfg_row_code | input | 2 | Row bits minus 11 |
| cfg_bank_code | input | 1 | Bank bits minus 1 |
| cfg_dbw16 | input | 1 | 1: 16-bit device, 0: 32-bit device |
| cfg_trcd | input | T_W | ACTIVATE to column command, clocks |
| cfg_tras | input | T_W | ACTIVATE to PRECHARGE minimum |
| cfg_twr | input | T_W | WRITE to PRECHARGE minimum |
| cfg_trp | input | T_W | PRECHARGE to next command |
| cfg_trc | input | T_W | ACTIVATE to ACTIVATE, and refresh to next command |
| cfg_ref_interval | input | REF_W | Clocks between refreshes |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_ready | output | 1 | Access accepted when high with req_valid |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | SA_W | SDRAM address bus |
| sd_ba | output | BA_W | SDRAM bank select |

## Verification
A refresh falling due and a new request both compete for the idle command slot, and they can meet in the same cycle. The bench provokes this by holding req_valid high over a long run of back-to-back normal accesses with a short refresh interval, so some refreshes fall due while an access is in progress. A scoreboard checks that every access's command sequence still arrives whole and in order. It also checks that no refresh appears between an ACTIVATE and its PRECHARGE, that each refresh keeps tRC to the next command, and that several refreshes were actually issued during the saturated run.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sd_cmd_e;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_PALL   = 2'd1,
    MODE_AREF   = 2'd2,
    MODE_LMR    = 2'd3
  } seq_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_TRCD,
    ST_HOLD,
    ST_WAIT
  } eng_state_e;

  localparam int TMRD_CYC = 3;
  localparam int AP_BIT   = 10;

endpackage

// File: rtl/sdram_addr_split.sv
module sdram_addr_split #(
  parameter int ADDR_W = 28,
  parameter int SA_W   = 13,
  parameter int BA_W   = 2
) (
  input  logic [ADDR_W-1:0] byte_addr,
  input  logic              dbw16,
  input  logic [1:0]        col_code,
  input  logic [1:0]        row_code,
  input  logic              bank_code,
  output logic [SA_W-1:0]   row,
  output logic [SA_W-1:0]   col,
  output logic [BA_W-1:0]   bank,
  output logic [SA_W-1:0]   word_sa,
  output logic [BA_W-1:0]   word_ba
);
  localparam int COL_BASE = 8;
  localparam int ROW_BASE = 11;

  logic [ADDR_W-1:0] word, after_col, after_row;
  logic [4:0]        col_n, row_n, bank_n;

  always_comb begin
    word      = dbw16 ? (byte_addr >> 1) : (byte_addr >> 2);
    col_n     = 5'(COL_BASE) + 5'(col_code);
    row_n     = 5'(ROW_BASE) + 5'(row_code);
    bank_n    = 5'd1 + 5'(bank_code);
    after_col = word >> col_n;
    after_row = after_col >> row_n;
    col       = SA_W'(word & ~({ADDR_W{1'b1}} << col_n));
    row       = SA_W'(after_col & ~({ADDR_W{1'b1}} << row_n));
    bank      = BA_W'(after_row & ~({ADDR_W{1'b1}} << bank_n));
    word_sa   = SA_W'(word);
    word_ba   = BA_W'(word >> SA_W);
  end
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int REF_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [REF_W-1:0] interval,
  input  logic             take,
  output logic             pend
);
  logic [REF_W-1:0] ctr;
  logic             expire;

  assign expire = run && (ctr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr  <= '0;
      pend <= 1'b0;
    end else begin
      if (!run || expire) ctr <= interval - 1'b1;
      else                ctr <= ctr - 1'b1;
      if (!run)        pend <= 1'b0;
      else if (expire) pend <= 1'b1;
      else if (take)   pend <= 1'b0;
    end
  end

  // R9: a refresh can only fall due while the timer runs
  assert_pend_needs_run_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(pend) |-> $past(run));
endmodule

// File: rtl/sdram_cmd_engine.sv
module sdram_cmd_engine
  import sdram_seq_pkg::*;
#(
  parameter int SA_W = 13,
  parameter int BA_W = 2,
  parameter int T_W  = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  seq_mode_e       mode,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [SA_W-1:0] row,
  input  logic [SA_W-1:0] col,
  input  logic [BA_W-1:0] bank,
  input  logic [SA_W-1:0] word_sa,
  input  logic [BA_W-1:0] word_ba,
  input  logic [T_W-1:0]  trcd,
  input  logic [T_W-1:0]  tras,
  input  logic [T_W-1:0]  twr,
  input  logic [T_W-1:0]  trp,
  input  logic [T_W-1:0]  trc,
  input  logic            ref_pend,
  output logic            req_ready,
  output logic            ref_take,
  output sd_cmd_e         cmd_q,
  output logic [SA_W-1:0] sa_q,
  output logic [BA_W-1:0] ba_q
);
  localparam logic [SA_W-1:0] AP_MASK = SA_W'(1) << AP_BIT;

  eng_state_e      st;
  logic [T_W-1:0]  cnt, ras_left, rc_left;
  logic [SA_W-1:0] col_h;
  logic [BA_W-1:0] ba_h;
  logic            wr_h;

  assign req_ready = (st == ST_IDLE) && !ref_pend;
  assign ref_take  = (st == ST_IDLE) && ref_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      ras_left <= '0;
      rc_left  <= '0;
      col_h    <= '0;
      ba_h     <= '0;
      wr_h     <= 1'b0;
      cmd_q    <= CMD_NOP;
      sa_q     <= '0;
      ba_q     <= '0;
    end else begin
      cmd_q <= CMD_NOP;
      if (ras_left != '0) ras_left <= ras_left - 1'b1;
      if (rc_left  != '0) rc_left  <= rc_left - 1'b1;
      unique case (st)
        ST_IDLE: begin
          if (ref_pend) begin
            cmd_q <= CMD_REF;
            cnt   <= trc - 1'b1;
            st    <= ST_WAIT;
          end else if (req_valid) begin
            unique case (mode)
              MODE_NORMAL: begin
                cmd_q    <= CMD_ACT;
                sa_q     <= row;
                ba_q     <= bank;
                ba_h     <= bank;
                col_h    <= col;
                wr_h     <= req_write;
                cnt      <= trcd - 1'b1;
                ras_left <= tras - 1'b1;
                rc_left  <= trc - 1'b1;
                st       <= ST_TRCD;
              end
              MODE_PALL: begin
                cmd_q <= CMD_PRE;
                sa_q  <= AP_MASK;
                ba_q  <= '0;
                cnt   <= trp - 1'b1;
                st    <= ST_WAIT;
              end
              MODE_AREF: begin
                cmd_q <= CMD_REF;
                cnt   <= trc - 1'b1;
                st    <= ST_WAIT;
              end
              default: begin
                cmd_q <= CMD_MRS;
                sa_q  <= word_sa;
                ba_q  <= word_ba;
                cnt   <= T_W'(TMRD_CYC - 1);
                st    <= ST_WAIT;
              end
            endcase
          end
        end
        ST_TRCD: begin
          if (cnt == '0) begin
            cmd_q <= wr_h ? CMD_WR : CMD_RD;
            sa_q  <= col_h & ~AP_MASK;
            ba_q  <= ba_h;
            cnt   <= wr_h ? (twr - 1'b1) : '0;
            st    <= ST_HOLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt == '0 && ras_left == '0) begin
            cmd_q <= CMD_PRE;
            sa_q  <= '0;
            ba_q  <= ba_h;
            cnt   <= trp - 1'b1;
            st    <= ST_WAIT;
          end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0 && rc_left == '0) st <= ST_IDLE;
          else if (cnt != '0)             cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  // Clocks since the last ACTIVATE on the bus, saturating; checker state only
  logic [T_W:0] act_age;
  always_ff @(posedge clk) begin
    if (rst)                    act_age <= '0;
    else if (cmd_q == CMD_ACT)  act_age <= (T_W+1)'(1);
    else if (act_age != '1)     act_age <= act_age + 1'b1;
  end

  // R6: column command lands exactly tRCD after its ACTIVATE
  assert_rw_after_trcd_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> act_age == {1'b0, trcd});

  // R7: single-bank precharge respects tRAS
  assert_pre_after_tras_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE && !sa_q[AP_BIT]) |-> act_age >= {1'b0, tras});
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int SA_W   = 13,
  parameter int BA_W   = 2,
  parameter int T_W    = 4,
  parameter int REF_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [1:0]        cfg_col_code,
  input  logic [1:0]        cfg_row_code,
  input  logic              cfg_bank_code,
  input  logic              cfg_dbw16,
  input  logic [T_W-1:0]    cfg_trcd,
  input  logic [T_W-1:0]    cfg_tras,
  input  logic [T_W-1:0]    cfg_twr,
  input  logic [T_W-1:0]    cfg_trp,
  input  logic [T_W-1:0]    cfg_trc,
  input  logic [REF_W-1:0]  cfg_ref_interval,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [SA_W-1:0]   sd_addr,
  output logic [BA_W-1:0]   sd_ba
);
  seq_mode_e       mode_e;
  logic            run, ref_pend, ref_take;
  logic [SA_W-1:0] row, col, word_sa;
  logic [BA_W-1:0] bank, word_ba;
  sd_cmd_e         cmd_q;

  assign mode_e = seq_mode_e'(mode);
  assign run    = (mode_e == MODE_NORMAL);

  sdram_addr_split #(.ADDR_W(ADDR_W), .SA_W(SA_W), .BA_W(BA_W)) u_split (
    .byte_addr (req_addr),
    .dbw16     (cfg_dbw16),
    .col_code  (cfg_col_code),
    .row_code  (cfg_row_code),
    .bank_code (cfg_bank_code),
    .row       (row),
    .col       (col),
    .bank      (bank),
    .word_sa   (word_sa),
    .word_ba   (word_ba)
  );

  sdram_refresh_timer #(.REF_W(REF_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .run      (run),
    .interval (cfg_ref_interval),
    .take     (ref_take),
    .pend     (ref_pend)
  );

  sdram_cmd_engine #(.SA_W(SA_W), .BA_W(BA_W), .T_W(T_W)) u_engine (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_e),
    .req_valid (req_valid),
    .req_write (req_write),
    .row       (row),
    .col       (col),
    .bank      (bank),
    .word_sa   (word_sa),
    .word_ba   (word_ba),
    .trcd      (cfg_trcd),
    .tras      (cfg_tras),
    .twr       (cfg_twr),
    .trp       (cfg_trp),
    .trc       (cfg_trc),
    .ref_pend  (ref_pend),
    .req_ready (req_ready),
    .ref_take  (ref_take),
    .cmd_q     (cmd_q),
    .sa_q      (sd_addr),
    .ba_q      (sd_ba)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  // R2: an accepted access drives a command in the following clock
  assert_accept_issues_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (cmd_q != CMD_NOP));

  // R10: a pending refresh is retired only by an AUTO-REFRESH on the bus
  assert_pend_retired_by_ref_R10: assert property (@(posedge clk) disable iff (rst)
    ($fell(ref_pend) && $past(run)) |-> (cmd_q == CMD_REF));
endmodule

// File: tb/test_sdram_cmd_seq.sv
module test_sdram_cmd_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_PRE = 4'b0010,
                         C_ACT = 4'b0011, C_WR  = 4'b0100, C_RD  = 4'b0101,
                         C_NOP = 4'b0111;

  logic clk = 0, rst = 1;
  logic [1:0] mode = 2'd1;
  logic [1:0] cfg_col_code = 2'd1, cfg_row_code = 2'd1;
  logic cfg_bank_code = 1'b1, cfg_dbw16 = 1'b0;
  logic [3:0] cfg_trcd = 4'd2, cfg_tras = 4'd5, cfg_twr = 4'd2, cfg_trp = 4'd2, cfg_trc = 4'd7;
  logic [15:0] cfg_ref_interval = 16'hFFFF;
  logic req_valid = 0, req_write = 0;
  logic [27:0] req_addr = '0;
  logic req_ready, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
  logic [12:0] sd_addr;
  logic [1:0] sd_ba;

  sdram_cmd_seq i_sdram_cmd_seq (
    .clk(clk), .rst(rst), .mode(mode),
    .cfg_col_code(cfg_col_code), .cfg_row_code(cfg_row_code),
    .cfg_bank_code(cfg_bank_code), .cfg_dbw16(cfg_dbw16),
    .cfg_trcd(cfg_trcd), .cfg_tras(cfg_tras), .cfg_twr(cfg_twr),
    .cfg_trp(cfg_trp), .cfg_trc(cfg_trc), .cfg_ref_interval(cfg_ref_interval),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_ready(req_ready), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic [3:0] cmd;
    int sa, sam, ba, bam;
    string tag;
  } exp_t;

  exp_t q[$];
  int vectors = 0, miscompares = 0;
  int cyc = 0;
  bit done = 0;
  int auto_refs = 0;
  bit gap_chk = 0;
  bit ref_seen = 0;
  int last_ref_t = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic void chk(input bit ok, input string tag, input string what,
                              input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endfunction

  function automatic void split(input logic [27:0] a, output int row, output int col,
                                output int bank);
    int w, cn, rn, bn;
    w  = cfg_dbw16 ? int'(a >> 1) : int'(a >> 2);
    cn = 8 + cfg_col_code;
    rn = 11 + cfg_row_code;
    bn = 1 + cfg_bank_code;
    col  = w % (1 << cn);
    row  = (w >> cn) % (1 << rn);
    bank = (w >> (cn + rn)) % (1 << bn);
  endfunction

  function automatic void push(input logic [3:0] c, input int sa, input int sam,
                               input int ba, input int bam, input string tag);
    exp_t e;
    e.cmd = c; e.sa = sa; e.sam = sam; e.ba = ba; e.bam = bam; e.tag = tag;
    q.push_back(e);
  endfunction

  // Driver: waits for ready, queues what the requirements predict, then lets the edge accept
  task automatic do_access(input bit wr, input logic [27:0] a);
    int r, c, b, w;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a;
    while (!req_ready) @(negedge clk);
    case (mode)
      2'd0: begin
        split(a, r, c, b);
        push(C_ACT, r, 32'h1FFF, b, 3, "R8");
        push(wr ? C_WR : C_RD, c, 32'h1FFF, b, 3, "R6");
        push(C_PRE, 0, 32'h0400, b, 3, "R7");
      end
      2'd1: push(C_PRE, 32'h0400, 32'h0400, 0, 0, "R3");
      2'd2: push(C_REF, 0, 0, 0, 0, "R4");
      default: begin
        w = cfg_dbw16 ? int'(a >> 1) : int'(a >> 2);
        push(C_MRS, w % 8192, 32'h1FFF, (w >> 13) % 4, 3, "R5");
      end
    endcase
    @(posedge clk);
  endtask

  task automatic idle_req();
    @(negedge clk);
    req_valid = 0;
  endtask

  // Monitor: timing rules and scoreboard comparison
  logic [3:0] last_cmd = C_NOP;
  int last_t = 0, t_act = 0, t_wr = 0;
  bit had_last = 0, had_act = 0, open_row = 0, last_was_wr = 0;

  always @(negedge clk) begin
    if (!gap_chk) ref_seen = 0;
    if (!rst && !done) begin
      logic [3:0] c;
      int t;
      exp_t e;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      t = cyc;
      if (c != C_NOP) begin
        if (had_last) begin
          if (last_cmd == C_REF) chk(t - last_t >= cfg_trc, "R4", "gap after refresh", t - last_t, cfg_trc);
          if (last_cmd == C_MRS) chk(t - last_t >= 3, "R5", "gap after load-mode", t - last_t, 3);
          if (last_cmd == C_PRE) chk(t - last_t >= cfg_trp, "R3", "gap after precharge", t - last_t, cfg_trp);
        end
        case (c)
          C_ACT: begin
            if (had_act) chk(t - t_act >= cfg_trc, "R7", "ACT to ACT", t - t_act, cfg_trc);
            t_act = t; had_act = 1; open_row = 1;
          end
          C_RD, C_WR: begin
            chk(t - t_act == cfg_trcd, "R6", "ACT to column", t - t_act, cfg_trcd);
            last_was_wr = (c == C_WR);
            if (c == C_WR) t_wr = t;
          end
          C_PRE: if (!sd_addr[10]) begin
            chk(t - t_act >= cfg_tras, "R7", "ACT to PRE", t - t_act, cfg_tras);
            if (last_was_wr) chk(t - t_wr >= cfg_twr, "R7", "WR to PRE", t - t_wr, cfg_twr);
            open_row = 0;
          end
          C_REF: chk(!open_row, "R10", "refresh inside open access", 1, 0);
          default: ;
        endcase
        if (c == C_REF && (q.size() == 0 || q[0].cmd != C_REF)) begin
          auto_refs++;
          if (gap_chk && ref_seen)
            chk(t - last_ref_t == cfg_ref_interval, "R9", "refresh period", t - last_ref_t, cfg_ref_interval);
          ref_seen = 1; last_ref_t = t;
        end else if (q.size() == 0) begin
          chk(0, "R2", "unexpected command", c, C_NOP);
        end else begin
          e = q.pop_front();
          chk(c == e.cmd, e.tag, "command code", c, e.cmd);
          chk((int'(sd_addr) & e.sam) == (e.sa & e.sam), e.tag, "address bus", int'(sd_addr) & e.sam, e.sa & e.sam);
          chk((int'(sd_ba) & e.bam) == (e.ba & e.bam), e.tag, "bank bus", int'(sd_ba) & e.bam, e.ba & e.bam);
        end
        last_cmd = c; last_t = t; had_last = 1;
      end
    end
  end

  task automatic drain();
    int n = 0;
    while (q.size() != 0 && n < 400) begin @(negedge clk); n++; end
    repeat (20) @(negedge clk);
    chk(q.size() == 0, "R2", "pending expected commands", q.size(), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
      finish_run();
    end
  end

  initial begin
    int n0, n1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "bus after reset",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);

    // R3 precharge-all
    mode = 2'd1;
    do_access(0, 28'h0);
    idle_req(); drain();

    // R4 eight refreshes in a row
    @(negedge clk); mode = 2'd2;
    for (int i = 0; i < 8; i++) do_access(0, 28'(i * 64));
    idle_req(); drain();

    // R5 load-mode with CAS latency 3 at word bit 4
    @(negedge clk); mode = 2'd3;
    do_access(1, 28'(3 << 6));
    idle_req(); drain();

    // R9 timer held outside normal mode
    @(negedge clk); cfg_ref_interval = 16'd30;
    n0 = auto_refs;
    repeat (100) @(negedge clk);
    chk(auto_refs == n0, "R9", "refreshes outside normal", auto_refs - n0, 0);

    // R9 exact period while idle in normal mode
    gap_chk = 1; mode = 2'd0;
    repeat (130) @(negedge clk);
    gap_chk = 0;
    chk(auto_refs - n0 >= 3, "R9", "refresh count idle", auto_refs - n0, 4);

    // R6 R7 R8 normal accesses, 32-bit device
    do_access(1, 28'h0A5_1234);
    do_access(0, 28'h7F3_0F0C);
    do_access(1, 28'h00F_FFFC);
    idle_req(); drain();

    // R8 different geometry, 16-bit device
    @(negedge clk);
    cfg_dbw16 = 1; cfg_col_code = 2'd0; cfg_row_code = 2'd2; cfg_bank_code = 1'b0;
    do_access(0, 28'h123_4566);
    do_access(1, 28'h0FF_00AA);
    idle_req(); drain();

    // R10 refresh against saturated back-to-back requests
    n1 = auto_refs;
    for (int i = 0; i < 14; i++) do_access(i[0], 28'(32'h0345_0000 + i * 32'h0001_2344));
    idle_req(); drain();
    chk(auto_refs - n1 >= 2, "R10", "refreshes under saturation", auto_refs - n1, 3);

    finish_run();
  end
endmodule